// File: doc/BRIEF.md
# Hub Port Timeout Supervisor with Link LED Blinking

This block watches every port of a multi-port network hub on each of its logical channels. When a request is forwarded out of a port on a channel, a watcher for that port and channel starts counting millisecond ticks. If the reply terminator comes back before the configured limit, the watcher returns to idle. If it does not, the watcher records a timeout in a sticky status bit. Software reads one status word per channel. Each word holds one bit per port and clears when it is read.

A single configuration word holds a 4-bit timeout code for each channel. Codes 0 to 7 select an exponential limit of 2^(2·code+1) ms, and any code with the top bit set turns timing off for that channel. Each port drives a link LED. A port with a pending timeout blinks slowly. A port marked for cable lookup blinks quickly, so a technician can find the cable. A port that is powered down stays dark. The millisecond tick and both blink periods come from parameters, so a simulation can run on a scaled-down tick.

Watcher states are Idle, Waiting and Expired. The transitions are:
- Idle to Waiting: a request is forwarded on an enabled port while no link reset is present.
- Waiting to Idle: a reply arrives, the port is disabled, or a link reset occurs.
- Waiting to Expired: the last tick of the limit arrives. This is the expire event, and it sets the status bit.
- Expired to Idle: a reply arrives, the port is disabled, or a link reset occurs.

Top module: `hub_port_timeout`

## Requirements
- R1: After reset the configuration word at address 4 reads 0x106F. Bits [4c+3:4c] hold the code of channel c, so channel 0 is off, channel 1 uses code 6, channel 2 uses code 0 and channel 3 uses code 1. A write at address 4 replaces the word.
- R2: For codes 0 to 7, the watcher sets status bit p of channel c when 2^(2·code+1) ticks pass after the request without a reply. The flag is not set before (limit−1) tick periods have elapsed, and it is set by the end of limit tick periods plus a few cycles.
- R3: A code with bit 3 set (0x8 to 0xF) never produces a timeout on that channel.
- R4: A reply that arrives before the limit returns the watcher to idle, and no flag is set.
- R5: Status flags are sticky. A read at address c (0 ≤ c < channel count) returns bit p = port p of channel c on reg_rdata in the cycle after reg_rd, then clears that word.
- R6: If a status read and a new expire event fall in the same cycle, the new bit stays set and appears in a later read.
- R7: A link reset returns all watchers to idle and cancels pending timeouts. It leaves the status flags unchanged.
- R8: While any channel flag of port p is set, led[p] blinks with a period of SLOW_MS ticks and is off for one quarter of each period.
- R9: When lookup bit p (address 5) is set, led[p] blinks with a period of FAST_MS ticks and is off for one quarter of each period. This takes priority over the timeout blink.
- R10: A port with no flag and no lookup shows link_up on its LED. When disable bit p (address 6) is set, led[p] is off, the port's watchers stay idle, and no flag is ever set for that port.
- R11: The lookup and disable words reset to 0 and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low chip reset |
| link_reset | input | 1 | Network reset pulse; returns watchers to idle |
| req_fwd | input | NUM_CHAN*NUM_PORTS | Request forwarded strobe, bit c*NUM_PORTS+p |
| reply_end | input | NUM_CHAN*NUM_PORTS | Reply terminator strobe, same bit layout |
| link_up | input | NUM_PORTS | Link established per port |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| led | output | NUM_PORTS | Link LED drive per port |

## Verification
The bench holds the status read strobe high while an expire event occurs. This places a read and a set in the same cycle. A design that let the clear win would never report that timeout. Each limit is probed just before and just after its window, which exposes a counter that is off by one tick or that decodes the exponent wrongly. Blink patterns are measured over one full slow period by counting on-cycles and rising edges. A design that swapped the fast and slow patterns, inverted the priority of lookup over timeout, or got the duty cycle wrong would produce the wrong counts. Link reset is applied both during a pending wait and after a flag is already set, so a design that cleared the flags on link reset, or did not cancel the pending wait, shows up.

// File: rtl/hub_to_pkg.sv
package hub_to_pkg;

    typedef enum logic [1:0] {
        W_IDLE    = 2'd0,
        W_WAIT    = 2'd1,
        W_EXPIRED = 2'd2
    } watch_state_t;

    localparam int CODE_W  = 4;
    localparam int LIMIT_W = 16;

    // Tick count for a code: 2^(2*code+1) when the top bit is clear.
    function automatic logic [LIMIT_W-1:0] code_limit(input logic [CODE_W-1:0] code);
        if (code[3])
            return '0;
        return LIMIT_W'(1) << {code[2:0], 1'b1};
    endfunction

    function automatic logic code_live(input logic [CODE_W-1:0] code);
        return !code[3];
    endfunction

endpackage

// File: rtl/hub_to_pace.sv
module hub_to_pace #(
    parameter int TICK_CYCLES = 125000,
    parameter int SLOW_MS     = 500,
    parameter int FAST_MS     = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic slow_on,
    output logic fast_on
);
    localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam int SW = (SLOW_MS > 1) ? $clog2(SLOW_MS) : 1;
    localparam int FW = (FAST_MS > 1) ? $clog2(FAST_MS) : 1;

    logic [TW-1:0] pre_q;
    logic [SW-1:0] slow_q;
    logic [FW-1:0] fast_q;

    assign tick = (pre_q == TW'(TICK_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            slow_q <= '0;
            fast_q <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                slow_q <= (slow_q == SW'(SLOW_MS - 1)) ? '0 : slow_q + 1'b1;
                fast_q <= (fast_q == FW'(FAST_MS - 1)) ? '0 : fast_q + 1'b1;
            end
        end
    end

    // Off during the first quarter of each period.
    assign slow_on = (slow_q >= SW'(SLOW_MS / 4));
    assign fast_on = (fast_q >= FW'(FAST_MS / 4));

endmodule

// File: rtl/hub_to_watch.sv
module hub_to_watch
    import hub_to_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    input  logic              req,
    input  logic              reply,
    output logic              expire
);
    watch_state_t       state_q, state_d;
    logic [LIMIT_W-1:0] cnt_q;
    logic [LIMIT_W-1:0] limit;
    logic               live;
    logic               last_tick;

    assign limit     = code_limit(code);
    assign live      = code_live(code);
    assign last_tick = tick && live && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= W_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (state_q != W_WAIT)
            cnt_q <= '0;
        else if (tick && live)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: begin
                if (enable && !restart && req)
                    state_d = W_WAIT;
            end
            W_WAIT: begin
                if (!enable || restart || reply)
                    state_d = W_IDLE;
                else if (last_tick)
                    state_d = W_EXPIRED;
            end
            W_EXPIRED: begin
                if (!enable || restart || reply)
                    state_d = W_IDLE;
            end
            default: state_d = W_IDLE;
        endcase
    end

    always_comb begin
        expire = (state_q == W_WAIT) && (state_d == W_EXPIRED);
    end

endmodule

// File: rtl/hub_port_timeout.sv
module hub_port_timeout
    import hub_to_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int NUM_CHAN    = 4,
    parameter int CLK_HZ      = 125_000_000,
    parameter int TICK_CYCLES = CLK_HZ / 1000,
    parameter int SLOW_MS     = 500,
    parameter int FAST_MS     = 125,
    parameter int DATA_W      = 16,
    parameter logic [4*NUM_CHAN-1:0] CFG_RESET = 16'h106F
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          link_reset,
    input  logic [NUM_CHAN*NUM_PORTS-1:0] req_fwd,
    input  logic [NUM_CHAN*NUM_PORTS-1:0] reply_end,
    input  logic [NUM_PORTS-1:0]          link_up,
    input  logic                          reg_rd,
    input  logic                          reg_wr,
    input  logic [2:0]                    reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic [NUM_PORTS-1:0]          led
);
    localparam int LANES = NUM_CHAN * NUM_PORTS;
    localparam int CFG_W = CODE_W * NUM_CHAN;
    localparam logic [2:0] ADDR_CFG  = 3'd4;
    localparam logic [2:0] ADDR_LOOK = 3'd5;
    localparam logic [2:0] ADDR_DIS  = 3'd6;

    logic [CFG_W-1:0]     cfg_q;
    logic [NUM_PORTS-1:0] look_q, dis_q;
    logic [LANES-1:0]     flag_q, flag_d, set_vec, clr_vec;
    logic [NUM_PORTS-1:0] any_flag;
    logic [DATA_W-1:0]    rd_mux;
    logic                 tick, slow_on, fast_on;

    hub_to_pace #(
        .TICK_CYCLES (TICK_CYCLES),
        .SLOW_MS     (SLOW_MS),
        .FAST_MS     (FAST_MS)
    ) pace_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .slow_on (slow_on),
        .fast_on (fast_on)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            hub_to_watch watch_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .enable  (!dis_q[p]),
                .restart (link_reset),
                .code    (cfg_q[c*CODE_W +: CODE_W]),
                .req     (req_fwd[c*NUM_PORTS + p]),
                .reply   (reply_end[c*NUM_PORTS + p]),
                .expire  (set_vec[c*NUM_PORTS + p])
            );
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RESET;
            look_q <= '0;
            dis_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_CFG:  cfg_q  <= reg_wdata[CFG_W-1:0];
                ADDR_LOOK: look_q <= reg_wdata[NUM_PORTS-1:0];
                ADDR_DIS:  dis_q  <= reg_wdata[NUM_PORTS-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_vec = '0;
        rd_mux  = '0;
        for (int c = 0; c < NUM_CHAN; c++) begin
            if (reg_addr == 3'(c)) begin
                clr_vec[c*NUM_PORTS +: NUM_PORTS] = {NUM_PORTS{reg_rd}};
                rd_mux[NUM_PORTS-1:0] = flag_q[c*NUM_PORTS +: NUM_PORTS];
            end
        end
        if (reg_addr == ADDR_CFG)  rd_mux[CFG_W-1:0]     = cfg_q;
        if (reg_addr == ADDR_LOOK) rd_mux[NUM_PORTS-1:0] = look_q;
        if (reg_addr == ADDR_DIS)  rd_mux[NUM_PORTS-1:0] = dis_q;
        // A set in the same cycle as the clear survives.
        flag_d = (flag_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q    <= '0;
            reg_rdata <= '0;
        end else begin
            flag_q <= flag_d;
            if (reg_rd)
                reg_rdata <= rd_mux;
        end
    end

    always_comb begin
        any_flag = '0;
        for (int c = 0; c < NUM_CHAN; c++)
            any_flag = any_flag | flag_q[c*NUM_PORTS +: NUM_PORTS];
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (dis_q[p])
                led[p] = 1'b0;
            else if (look_q[p])
                led[p] = fast_on;
            else if (any_flag[p])
                led[p] = slow_on;
            else
                led[p] = link_up[p];
        end
    end

endmodule

// File: rtl/hub_port_timeout_chk.sv
module hub_port_timeout_chk #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_CHAN  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_rd,
    input logic [2:0]                    reg_addr,
    input logic [NUM_CHAN*NUM_PORTS-1:0] flag_q,
    input logic [NUM_CHAN*NUM_PORTS-1:0] set_vec,
    input logic [NUM_PORTS-1:0]          dis_q,
    input logic [NUM_PORTS-1:0]          look_q,
    input logic [NUM_PORTS-1:0]          link_up,
    input logic [NUM_PORTS-1:0]          led
);
    logic [NUM_PORTS-1:0] pend;

    always_comb begin
        pend = '0;
        for (int c = 0; c < NUM_CHAN; c++)
            pend = pend | flag_q[c*NUM_PORTS +: NUM_PORTS];
    end

    AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R5

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_rc
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && reg_addr == 3'(c)) |=>
            ((flag_q[c*NUM_PORTS +: NUM_PORTS] & ~$past(set_vec[c*NUM_PORTS +: NUM_PORTS])) == '0)); // R6
    end

    AST_NO_EXPIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec & {NUM_CHAN{dis_q}}) == '0); // R10

    AST_DARK_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (led & dis_q) == '0); // R10

    AST_LED_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (led & ~link_up & ~look_q & ~pend) == '0); // R8

endmodule

bind hub_port_timeout hub_port_timeout_chk #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_CHAN  (NUM_CHAN)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .flag_q   (flag_q),
    .set_vec  (set_vec),
    .dis_q    (dis_q),
    .look_q   (look_q),
    .link_up  (link_up),
    .led      (led)
);

// File: tb/hub_port_timeout_tb_top.sv
`timescale 1ns/1ps
module hub_port_timeout_tb_top;
    localparam int NP = 4;
    localparam int NC = 4;
    localparam int T  = 4;
    localparam int SLOW = 16;
    localparam int FAST = 4;
    localparam int WIN  = SLOW * T;
    // {chan, port, code, early_reply}
    localparam logic [15:0] VEC [6] = '{16'h0000, 16'h1110, 16'h2201,
                                        16'h3320, 16'h1211, 16'h0330};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_reset = 1'b0;
    logic [NC*NP-1:0] req_fwd = '0, reply_end = '0;
    logic [NP-1:0] link_up = 4'b0111;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [NP-1:0] led;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    hub_port_timeout #(
        .NUM_PORTS(NP), .NUM_CHAN(NC), .TICK_CYCLES(T),
        .SLOW_MS(SLOW), .FAST_MS(FAST)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .link_reset(link_reset),
        .req_fwd(req_fwd), .reply_end(reply_end), .link_up(link_up),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .led(led)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse_req(input int lane);
        req_fwd[lane] = 1'b1;
        @(negedge clk);
        req_fwd[lane] = 1'b0;
    endtask

    task automatic pulse_reply(input int lane);
        reply_end[lane] = 1'b1;
        @(negedge clk);
        reply_end[lane] = 1'b0;
    endtask

    task automatic clear_flags();
        logic [15:0] d;
        for (int c = 0; c < NC; c++) reg_read(3'(c), d);
    endtask

    task automatic measure(input int p, output int on_cnt, output int rises);
        logic prev;
        prev = led[p]; on_cnt = 0; rises = 0;
        repeat (WIN) begin
            @(negedge clk);
            if (led[p]) on_cnt++;
            if (led[p] && !prev) rises++;
            prev = led[p];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] d;
        int on_c, rs, seen;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // Reset state
        reg_read(3'd4, d); chk("R1 cfg reset", d, 16'h106F);
        reg_read(3'd5, d); chk("R11 lookup reset", d, 0);
        reg_read(3'd6, d); chk("R11 disable reset", d, 0);
        reg_read(3'd1, d); chk("R5 status reset", d, 0);
        chk("R10 led follows link", led, 4'b0111);

        // Vector table: limits and early replies
        for (int i = 0; i < 6; i++) begin
            int ch, pt, cd, lim, lane;
            logic early;
            logic [15:0] cfg;
            ch = int'(VEC[i][15:12]); pt = int'(VEC[i][11:8]);
            cd = int'(VEC[i][7:4]);   early = VEC[i][0];
            lim = 1 << (2*cd + 1);
            lane = ch*NP + pt;
            cfg = 16'hFFFF;
            cfg[ch*4 +: 4] = 4'(cd);
            reg_write(3'd4, cfg);
            clear_flags();
            pulse_req(lane);
            if (early) begin
                wait_cyc(lim*T/4);
                pulse_reply(lane);
                wait_cyc(lim*T + 8);
                reg_read(3'(ch), d); chk("R4 early reply no flag", d, 0);
            end else begin
                wait_cyc((lim-1)*T - 3);
                reg_read(3'(ch), d); chk("R2 not before limit", d, 0);
                wait_cyc(T + 8);
                reg_read(3'(ch), d); chk("R2 flag at limit", d, 16'(1 << pt));
                pulse_reply(lane);
            end
        end

        // R1 write/readback
        reg_write(3'd4, 16'hA5C3);
        reg_read(3'd4, d); chk("R1 cfg write", d, 16'hA5C3);

        // R3 disabled codes 8 and F
        reg_write(3'd4, 16'hFFF8);
        clear_flags();
        pulse_req(0); pulse_req(3*NP);
        wait_cyc(150);
        reg_read(3'd0, d); chk("R3 code 8 no timeout", d, 0);
        reg_read(3'd3, d); chk("R3 code F no timeout", d, 0);
        pulse_reply(0); pulse_reply(3*NP);

        // R5 sticky then cleared
        reg_write(3'd4, 16'h0FFF);
        clear_flags();
        pulse_req(3*NP + 2);
        wait_cyc(70);
        reg_read(3'd3, d); chk("R5 sticky flag", d, 16'h0004);
        reg_read(3'd3, d); chk("R5 cleared by read", d, 0);
        pulse_reply(3*NP + 2);

        // R6 read held across the expire event
        reg_write(3'd4, 16'hF0FF);
        clear_flags();
        pulse_req(2*NP + 3);
        reg_addr = 3'd2; reg_rd = 1'b1;
        seen = 0;
        repeat (30) begin
            @(negedge clk);
            if (reg_rdata[3]) seen++;
        end
        reg_rd = 1'b0;
        chk("R6 coincident set survives", seen, 1);
        reg_read(3'd2, d); chk("R6 no stale bit", d, 0);
        pulse_reply(2*NP + 3);

        // R7 link reset
        reg_write(3'd4, 16'hFFF1);
        clear_flags();
        pulse_req(2);
        wait_cyc(10);
        link_reset = 1'b1; @(negedge clk); link_reset = 1'b0;
        wait_cyc(60);
        reg_read(3'd0, d); chk("R7 pending cancelled", d, 0);
        pulse_req(2);
        wait_cyc(50);
        link_reset = 1'b1; @(negedge clk); link_reset = 1'b0;
        reg_read(3'd0, d); chk("R7 flag kept", d, 16'h0004);

        // R8 slow blink on timeout
        reg_write(3'd4, 16'hFF0F);
        clear_flags();
        link_up = 4'b1111;
        pulse_req(NP + 1);
        wait_cyc(30);
        measure(1, on_c, rs);
        chk("R8 slow on-cycles", on_c, WIN*3/4);
        chk("R8 slow edges", rs, 1);
        measure(0, on_c, rs);
        chk("R10 steady link led", on_c, WIN);

        // R9 fast blink, priority over timeout
        reg_write(3'd5, 16'h0002);
        measure(1, on_c, rs);
        chk("R9 fast over slow edges", rs, SLOW/FAST);
        chk("R9 fast on-cycles", on_c, WIN*3/4);
        reg_write(3'd5, 16'h0006);
        measure(2, on_c, rs);
        chk("R9 fast no flag edges", rs, SLOW/FAST);
        reg_read(3'd5, d); chk("R11 lookup readback", d, 16'h0006);
        reg_write(3'd5, 16'h0000);
        clear_flags();
        measure(1, on_c, rs);
        chk("R10 back to link level", on_c, WIN);

        // R10 disabled port
        reg_write(3'd6, 16'h0001);
        reg_write(3'd5, 16'h0001);
        reg_write(3'd4, 16'hFFF0);
        pulse_req(0);
        wait_cyc(40);
        chk("R10 disabled led dark", led[0], 0);
        reg_read(3'd0, d); chk("R10 disabled no flag", d, 0);
        reg_read(3'd6, d); chk("R11 disable readback", d, 16'h0001);

        summary();
        $finish;
    end
endmodule